// File: doc/BRIEF.md
# Two-Processor Doorbell Flag Controller

This block lets two processors signal each other through per-channel doorbell flags. Each processor owns a small register bank that holds an interrupt enable word, a per-channel mask word, a write-only set/acknowledge word and a read-only status word. A processor rings channel n by setting the occupied flag in its own status word. The peer sees that flag, does its work, and writes an acknowledge that clears the flag. There is no payload storage: the flags only say "a message is waiting" and "the slot is free again".

Each processor has its own single-cycle register port. A request is a one-cycle pulse of `valid` carrying `write`, a byte address and write data. Read data appears on the port in the cycle after the request and is zero in every other cycle. Each processor gets two level interrupts. The receive interrupt fires while any unmasked channel is occupied in the peer's status. The transmit interrupt fires while any unmasked channel is free in the processor's own status.

Top module: `dual_cpu_doorbell`

## Requirements
- R1: After reset all status flags are 0, both enable bits of both banks are 0, every implemented mask bit is 1 (a mask reads 0x0FFF0FFF with 12 channels), and all four interrupts are low.
- R2: Map: bank 0 is at 0x000 and bank 1 at 0x010. Inside a bank, control is at +0x0, mask at +0x4, set/acknowledge at +0x8 and status at +0xC. A processor that writes 1 to bit 16+n of its own set/acknowledge word sets channel n, which appears as bit n of its own status word. Either processor can read either status word.
- R3: A processor that writes 1 to bit n of its own set/acknowledge word clears channel n in the peer's status word and leaves its own status word unchanged. Zero bits in that write change nothing.
- R4: If one processor sets channel n in the same cycle that the peer acknowledges it, the flag ends up set.
- R5: Control bit 0 enables the receive interrupt, and mask bit n gates channel n. The receive interrupt is high while the enable is set and the peer has an occupied channel whose mask bit is clear. It follows the flags one clock later.
- R6: Control bit 16 enables the transmit interrupt, and mask bit 16+n gates channel n. The transmit interrupt is high while the enable is set and the processor's own status has a free channel whose mask bit is clear. It also follows the flags one clock later.
- R7: Writes to a status word, and writes by a processor into the peer's bank, have no effect. The set/acknowledge word reads as zero.
- R8: Address 0x3F0 reads the channel count in bits 7:0. Address 0x3F4 reads the major revision in bits 7:4 and the minor revision in bits 3:0.
- R9: Bits that belong to channels at or above the configured count read as zero, and writing them sets no flag and unmasks nothing.
- R10: Read data is valid in the cycle after a read request and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| p0Valid | input | 1 | Processor 0 request strobe |
| p0Write | input | 1 | Processor 0 write (1) or read (0) |
| p0Addr | input | ADDR_W | Processor 0 byte address |
| p0WrData | input | 32 | Processor 0 write data |
| p0RdData | output | 32 | Processor 0 read data, one cycle after the request |
| p1Valid | input | 1 | Processor 1 request strobe |
| p1Write | input | 1 | Processor 1 write (1) or read (0) |
| p1Addr | input | ADDR_W | Processor 1 byte address |
| p1WrData | input | 32 | Processor 1 write data |
| p1RdData | output | 32 | Processor 1 read data, one cycle after the request |
| p0RxIrq | output | 1 | Processor 0 receive interrupt |
| p0TxIrq | output | 1 | Processor 0 transmit-free interrupt |
| p1RxIrq | output | 1 | Processor 1 receive interrupt |
| p1TxIrq | output | 1 | Processor 1 transmit-free interrupt |

## Verification
The bench checks that an acknowledge clears the peer's flag and not the writer's own flag. A design that confused the two banks would leave a doorbell stuck or drop a message the sender never saw delivered. A set and an acknowledge of the same channel are driven in the same cycle; a design that gave the clear priority would lose a fresh doorbell. Writes to the status word, writes into the peer's bank and writes to bits of unimplemented channels must all leave the readable state unchanged, so a design with a loose decode shows up as corrupted flags or masks. The interrupt checks are timed to the cycle, so an interrupt that reacts with no register stage, or that ignores its enable or mask, is caught.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_CTRL,
    RS_MASK,
    RS_SETCLR,
    RS_STATUS,
    RS_COUNT,
    RS_VERSION
  } regSel_e;

  // Strobes from one port's decoder to the datapath.
  typedef struct packed {
    logic        wrCtrl;
    logic        wrMask;
    logic        wrSetClr;
    logic        rdEn;
    logic        rdBank;
    regSel_e     rdSel;
    logic [31:0] wrData;
  } portStrobe_t;

  localparam int NUM_PROC   = 2;
  localparam int HALF_WORD  = 16;
  localparam int RX_EN_BIT  = 0;
  localparam int TX_EN_BIT  = 16;

endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
  import doorbell_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int PORT_ID = 0
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output portStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] COUNT_ADDR = ADDR_W'('h3F0);
  localparam logic [ADDR_W-1:0] VER_ADDR   = ADDR_W'('h3F4);
  localparam logic              OWN_BANK   = 1'(PORT_ID);

  logic       inBanks;
  logic       bankSel;
  logic [1:0] regOff;
  logic       aligned;
  logic       wrOwn;

  assign inBanks = (addr[ADDR_W-1:5] == '0);
  assign bankSel = addr[4];
  assign regOff  = addr[3:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wrOwn   = valid && write && inBanks && aligned && (bankSel == OWN_BANK);

  always_comb begin
    strobe          = '0;
    strobe.wrData   = wrData;
    strobe.rdBank   = bankSel;
    strobe.rdSel    = RS_NONE;
    strobe.wrCtrl   = wrOwn && (regOff == 2'd0);
    strobe.wrMask   = wrOwn && (regOff == 2'd1);
    strobe.wrSetClr = wrOwn && (regOff == 2'd2);
    strobe.rdEn     = valid && !write;
    if (inBanks && aligned) begin
      unique case (regOff)
        2'd0:    strobe.rdSel = RS_CTRL;
        2'd1:    strobe.rdSel = RS_MASK;
        2'd2:    strobe.rdSel = RS_SETCLR;
        default: strobe.rdSel = RS_STATUS;
      endcase
    end else if (addr == COUNT_ADDR) begin
      strobe.rdSel = RS_COUNT;
    end else if (addr == VER_ADDR) begin
      strobe.rdSel = RS_VERSION;
    end
  end

endmodule

// File: rtl/doorbell_datapath.sv
module doorbell_datapath
  import doorbell_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 0
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  portStrobe_t [NUM_PROC-1:0]       strobes,
  output logic [NUM_PROC-1:0][31:0]        rdData,
  output logic [NUM_PROC-1:0]              irqRx,
  output logic [NUM_PROC-1:0]              irqTx,
  output logic [NUM_PROC-1:0][NUM_CH-1:0]  flagState
);

  localparam logic [7:0] VER_BYTE = {4'(VER_MAJOR), 4'(VER_MINOR)};

  logic [NUM_PROC-1:0]             ctrlRxAll;
  logic [NUM_PROC-1:0]             ctrlTxAll;
  logic [NUM_PROC-1:0][NUM_CH-1:0] maskRxAll;
  logic [NUM_PROC-1:0][NUM_CH-1:0] maskTxAll;
  logic [NUM_PROC-1:0][NUM_CH-1:0] flagsAll;
  logic [NUM_PROC-1:0][NUM_CH-1:0] setAll;
  logic [NUM_PROC-1:0][NUM_CH-1:0] ackAll;

  assign flagState = flagsAll;

  for (genvar p = 0; p < NUM_PROC; p++) begin : gProc
    localparam int PEER = NUM_PROC - 1 - p;

    logic              ctrlRxQ;
    logic              ctrlTxQ;
    logic [NUM_CH-1:0] maskRxQ;
    logic [NUM_CH-1:0] maskTxQ;
    logic [NUM_CH-1:0] flagsQ;
    logic              irqRxQ;
    logic              irqTxQ;
    logic [31:0]       rdQ;
    logic [31:0]       rdNext;
    logic              rdB;

    assign setAll[p] = strobes[p].wrSetClr ? strobes[p].wrData[HALF_WORD +: NUM_CH] : '0;
    assign ackAll[p] = strobes[p].wrSetClr ? strobes[p].wrData[0 +: NUM_CH]         : '0;

    // Enables and masks belong to the owning processor only.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlRxQ <= 1'b0;
        ctrlTxQ <= 1'b0;
        maskRxQ <= '1;
        maskTxQ <= '1;
      end else begin
        if (strobes[p].wrCtrl) begin
          ctrlRxQ <= strobes[p].wrData[RX_EN_BIT];
          ctrlTxQ <= strobes[p].wrData[TX_EN_BIT];
        end
        if (strobes[p].wrMask) begin
          maskRxQ <= strobes[p].wrData[0 +: NUM_CH];
          maskTxQ <= strobes[p].wrData[HALF_WORD +: NUM_CH];
        end
      end
    end

    // Occupied flags: set by the owner, cleared by the peer, set wins.
    always_ff @(posedge clk) begin
      if (!rstN) flagsQ <= '0;
      else       flagsQ <= (flagsQ & ~ackAll[PEER]) | setAll[p];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        irqRxQ <= 1'b0;
        irqTxQ <= 1'b0;
      end else begin
        irqRxQ <= ctrlRxQ && |(flagsAll[PEER] & ~maskRxQ);
        irqTxQ <= ctrlTxQ && |(~flagsQ & ~maskTxQ);
      end
    end

    assign rdB = strobes[p].rdBank;

    always_comb begin
      unique case (strobes[p].rdSel)
        RS_CTRL:    rdNext = {15'b0, ctrlTxAll[rdB], 15'b0, ctrlRxAll[rdB]};
        RS_MASK:    rdNext = {16'(maskTxAll[rdB]), 16'(maskRxAll[rdB])};
        RS_STATUS:  rdNext = {16'b0, 16'(flagsAll[rdB])};
        RS_COUNT:   rdNext = {24'b0, 8'(NUM_CH)};
        RS_VERSION: rdNext = {24'b0, VER_BYTE};
        default:    rdNext = '0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN)                rdQ <= '0;
      else if (strobes[p].rdEn) rdQ <= rdNext;
      else                      rdQ <= '0;
    end

    assign ctrlRxAll[p] = ctrlRxQ;
    assign ctrlTxAll[p] = ctrlTxQ;
    assign maskRxAll[p] = maskRxQ;
    assign maskTxAll[p] = maskTxQ;
    assign flagsAll[p]  = flagsQ;
    assign irqRx[p]     = irqRxQ;
    assign irqTx[p]     = irqTxQ;
    assign rdData[p]    = rdQ;
  end

endmodule

// File: rtl/dual_cpu_doorbell.sv
module dual_cpu_doorbell
  import doorbell_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int ADDR_W    = 10,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              p0Valid,
  input  logic              p0Write,
  input  logic [ADDR_W-1:0] p0Addr,
  input  logic [31:0]       p0WrData,
  output logic [31:0]       p0RdData,
  input  logic              p1Valid,
  input  logic              p1Write,
  input  logic [ADDR_W-1:0] p1Addr,
  input  logic [31:0]       p1WrData,
  output logic [31:0]       p1RdData,
  output logic              p0RxIrq,
  output logic              p0TxIrq,
  output logic              p1RxIrq,
  output logic              p1TxIrq
);

  logic [NUM_PROC-1:0]              validV;
  logic [NUM_PROC-1:0]              writeV;
  logic [NUM_PROC-1:0][ADDR_W-1:0]  addrV;
  logic [NUM_PROC-1:0][31:0]        wdataV;
  portStrobe_t [NUM_PROC-1:0]       strobes;
  logic [NUM_PROC-1:0][31:0]        rdV;
  logic [NUM_PROC-1:0]              irqRxV;
  logic [NUM_PROC-1:0]              irqTxV;
  logic [NUM_PROC-1:0][NUM_CH-1:0]  flagState;

  assign validV = {p1Valid, p0Valid};
  assign writeV = {p1Write, p0Write};
  assign addrV  = {p1Addr, p0Addr};
  assign wdataV = {p1WrData, p0WrData};

  for (genvar p = 0; p < NUM_PROC; p++) begin : gDec
    doorbell_decode #(.ADDR_W(ADDR_W), .PORT_ID(p)) uDec (
      .valid  (validV[p]),
      .write  (writeV[p]),
      .addr   (addrV[p]),
      .wrData (wdataV[p]),
      .strobe (strobes[p])
    );
  end

  doorbell_datapath #(
    .NUM_CH(NUM_CH), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rdData    (rdV),
    .irqRx     (irqRxV),
    .irqTx     (irqTxV),
    .flagState (flagState)
  );

  assign p0RdData = rdV[0];
  assign p1RdData = rdV[1];
  assign p0RxIrq  = irqRxV[0];
  assign p1RxIrq  = irqRxV[1];
  assign p0TxIrq  = irqTxV[0];
  assign p1TxIrq  = irqTxV[1];

endmodule

// File: rtl/doorbell_checker.sv
module doorbell_checker #(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 10
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   p0Valid,
  input logic                   p0Write,
  input logic [ADDR_W-1:0]      p0Addr,
  input logic [31:0]            p0WrData,
  input logic                   p1Valid,
  input logic                   p1Write,
  input logic [ADDR_W-1:0]      p1Addr,
  input logic [31:0]            p1WrData,
  input logic                   p0RxIrq,
  input logic                   p0TxIrq,
  input logic                   p1RxIrq,
  input logic                   p1TxIrq,
  input logic [1:0][NUM_CH-1:0] flagState
);

  logic sc0;
  logic sc1;
  assign sc0 = p0Valid && p0Write && (p0Addr == ADDR_W'('h008));
  assign sc1 = p1Valid && p1Write && (p1Addr == ADDR_W'('h018));

  for (genvar k = 0; k < NUM_CH; k++) begin : gCh
    AST_SET_RAISES_P0: assert property (@(posedge clk) disable iff (!rstN)
      (sc0 && p0WrData[16+k]) |=> flagState[0][k]); // R4
    AST_SET_RAISES_P1: assert property (@(posedge clk) disable iff (!rstN)
      (sc1 && p1WrData[16+k]) |=> flagState[1][k]); // R2
    AST_ACK_DROPS_P0: assert property (@(posedge clk) disable iff (!rstN)
      (sc1 && p1WrData[k] && !(sc0 && p0WrData[16+k])) |=> !flagState[0][k]); // R3
    AST_ACK_DROPS_P1: assert property (@(posedge clk) disable iff (!rstN)
      (sc0 && p0WrData[k] && !(sc1 && p1WrData[16+k])) |=> !flagState[1][k]); // R3
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sc0 && !sc1) |=> $stable(flagState)); // R7
  AST_RX0_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (flagState[1] == '0) |=> !p0RxIrq); // R5
  AST_RX1_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (flagState[0] == '0) |=> !p1RxIrq); // R5
  AST_TX0_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&flagState[0]) |=> !p0TxIrq); // R6
  AST_TX1_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&flagState[1]) |=> !p1TxIrq); // R6

endmodule

bind dual_cpu_doorbell doorbell_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uChk (.*);

// File: tb/sim_dual_cpu_doorbell.sv
`timescale 1ns/1ps
module sim_dual_cpu_doorbell;

  localparam int NCH = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        p0Valid = 0, p0Write = 0, p1Valid = 0, p1Write = 0;
  logic [9:0]  p0Addr = '0, p1Addr = '0;
  logic [31:0] p0WrData = '0, p1WrData = '0;
  logic [31:0] p0RdData, p1RdData;
  logic        p0RxIrq, p0TxIrq, p1RxIrq, p1TxIrq;
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  dual_cpu_doorbell #(.NUM_CH(NCH), .ADDR_W(10), .VER_MAJOR(2), .VER_MINOR(5)) u0 (.*);

  typedef struct packed {
    logic        port;
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t TABLE [NVEC] = '{
    '{1'b0, 1'b0, 10'h004, 32'h0,        32'h0FFF0FFF, 4'd1},  // R1 mask reset
    '{1'b1, 1'b0, 10'h014, 32'h0,        32'h0FFF0FFF, 4'd1},  // R1
    '{1'b0, 1'b0, 10'h000, 32'h0,        32'h0,        4'd1},  // R1 control
    '{1'b0, 1'b0, 10'h00C, 32'h0,        32'h0,        4'd1},  // R1 status
    '{1'b0, 1'b0, 10'h3F0, 32'h0,        32'd12,       4'd8},  // R8 count
    '{1'b1, 1'b0, 10'h3F4, 32'h0,        32'h25,       4'd8},  // R8 version
    '{1'b0, 1'b1, 10'h008, 32'h00050000, 32'h0,        4'd10}, // R10 write reads zero
    '{1'b0, 1'b0, 10'h00C, 32'h0,        32'h5,        4'd2},  // R2
    '{1'b1, 1'b0, 10'h00C, 32'h0,        32'h5,        4'd2},  // R2 peer reads
    '{1'b0, 1'b0, 10'h008, 32'h0,        32'h0,        4'd7},  // R7 set/ack reads 0
    '{1'b1, 1'b1, 10'h00C, 32'hFFFF,     32'h0,        4'd7},  // R7
    '{1'b0, 1'b0, 10'h00C, 32'h0,        32'h5,        4'd7},  // R7
    '{1'b1, 1'b1, 10'h000, 32'h00010001, 32'h0,        4'd7},  // R7 peer bank
    '{1'b0, 1'b0, 10'h000, 32'h0,        32'h0,        4'd7},  // R7
    '{1'b1, 1'b1, 10'h018, 32'h00000001, 32'h0,        4'd3},  // R3 ack ch0
    '{1'b0, 1'b0, 10'h00C, 32'h0,        32'h4,        4'd3},  // R3
    '{1'b0, 1'b1, 10'h008, 32'h00000004, 32'h0,        4'd3},  // R3 own ack
    '{1'b0, 1'b0, 10'h00C, 32'h0,        32'h4,        4'd3},  // R3 own kept
    '{1'b0, 1'b1, 10'h008, 32'hF0000000, 32'h0,        4'd9},  // R9 unused set
    '{1'b0, 1'b0, 10'h00C, 32'h0,        32'h4,        4'd9},  // R9
    '{1'b0, 1'b1, 10'h004, 32'hFFFFFFFF, 32'h0,        4'd9},  // R9
    '{1'b0, 1'b0, 10'h004, 32'h0,        32'h0FFF0FFF, 4'd9},  // R9
    '{1'b1, 1'b1, 10'h018, 32'h00000004, 32'h0,        4'd3},  // R3
    '{1'b0, 1'b0, 10'h00C, 32'h0,        32'h0,        4'd3}   // R3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busOp(input logic port, input logic wr, input logic [9:0] a,
                       input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    if (!port) begin p0Valid = 1; p0Write = wr; p0Addr = a; p0WrData = d; end
    else       begin p1Valid = 1; p1Write = wr; p1Addr = a; p1WrData = d; end
    @(negedge clk);
    rd = port ? p1RdData : p0RdData;
    p0Valid = 0; p1Valid = 0;
  endtask

  task automatic wr(input logic port, input logic [9:0] a, input logic [31:0] d);
    logic [31:0] unused;
    busOp(port, 1'b1, a, d, unused);
  endtask

  task automatic rdChk(input logic port, input logic [9:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    busOp(port, 1'b0, a, 32'h0, v);
    check(tag, v, exp);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 irqs", {28'b0, p0RxIrq, p0TxIrq, p1RxIrq, p1TxIrq}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      busOp(TABLE[i].port, TABLE[i].wr, TABLE[i].addr, TABLE[i].data, v);
      check($sformatf("R%0d vec%0d", TABLE[i].req, i), v, TABLE[i].exp);
    end

    // R6 transmit-free interrupt
    wr(0, 10'h000, 32'h00010000);
    @(negedge clk);
    check("R6 masked", {31'b0, p0TxIrq}, 32'h0);
    wr(0, 10'h004, 32'h0FFD0FFF);
    @(negedge clk);
    check("R6 free unmasked", {31'b0, p0TxIrq}, 32'h1);
    wr(0, 10'h008, 32'h00020000);
    @(negedge clk);
    check("R6 occupied", {31'b0, p0TxIrq}, 32'h0);

    // R5 receive interrupt on peer
    wr(1, 10'h010, 32'h00000001);
    wr(1, 10'h014, 32'h0FFF0FFD);
    @(negedge clk);
    check("R5 rx high", {31'b0, p1RxIrq}, 32'h1);
    check("R5 rx p0 masked", {31'b0, p0RxIrq}, 32'h0);
    wr(1, 10'h018, 32'h00000002);
    check("R5 rx one-cycle lag", {31'b0, p1RxIrq}, 32'h1);
    @(negedge clk);
    check("R5 rx cleared", {31'b0, p1RxIrq}, 32'h0);
    check("R6 tx free again", {31'b0, p0TxIrq}, 32'h1);
    wr(0, 10'h000, 32'h0);
    @(negedge clk);
    check("R6 disabled", {31'b0, p0TxIrq}, 32'h0);

    // R4 simultaneous set and acknowledge
    wr(0, 10'h008, 32'h00080000);
    @(negedge clk);
    p0Valid = 1; p0Write = 1; p0Addr = 10'h008; p0WrData = 32'h00080000;
    p1Valid = 1; p1Write = 1; p1Addr = 10'h018; p1WrData = 32'h00000008;
    @(negedge clk);
    p0Valid = 0; p1Valid = 0;
    rdChk(0, 10'h00C, 32'h8, "R4 set wins");
    wr(1, 10'h018, 32'h00000008);
    rdChk(0, 10'h00C, 32'h0, "R4 then ack clears");
    check("R10 idle read data", p0RdData, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule